// File: doc/BRIEF.md
# Split-Chain Carry Lookahead Adder

This block adds two unsigned operands and a carry-in, returning the sum and a carry-out. Its carries do not ripple from one bit to the next. For every bit it first forms three terms: a generate (both operand bits set), an XOR-propagate and an OR-propagate. It then merges each pair of neighbouring bits into a group generate and a group propagate.

Two independent pseudo-carry chains use these group terms. One chain covers the even bit positions and the other covers the odd positions. Each link in a chain reaches back two bit positions, so each chain is only half as long as the operand. The true carry out of each bit is the pseudo-carry gated by that bit's OR-propagate. Each sum bit is the bit's XOR-propagate XORed with the true carry from the bit below.

The adder logic is combinational. Its result is captured in an output register with a synchronous, active-high reset, so a result appears one clock after its operands are presented. The operand width is a parameter that must be even. Its default is 8 bits.

Top module: `split_cla_adder`

## Requirements
- R1: One clock after an edge that samples operands `a_in`, `b_in` and carry-in `c_in`, the 9-bit value {`cout_q`, `sum_q`} equals the arithmetic sum a_in + b_in + c_in, for every operand pair with carry-in 1.
- R2: When `rst` is high at a rising clock edge, `sum_q` and `cout_q` are zero after that edge, whatever the operands.
- R3: With `c_in` at 0, the result equals plain unsigned addition of the two operands for every operand pair. This includes 0xFF + 0xFF, which gives `sum_q` = 0xFE and `cout_q` = 1.
- R4: A carry-in that has to travel through every bit on propagate alone reaches the carry-out: 0xFF + 0x00 + 1 gives `sum_q` = 0x00 and `cout_q` = 1. The same holds for 0x55 + 0xAA + 1.
- R5: A carry generated at bit 0, on the even chain, reaches the odd positions and the carry-out: 0x01 + 0xFF + 0 gives `sum_q` = 0x00 and `cout_q` = 1. A carry generated at bit 1, on the odd chain, reaches the even positions: 0x02 + 0xFE + 0 gives 0x00 with `cout_q` = 1.
- R6: Zero operands with carry-in 0 give `sum_q` = 0x00 and `cout_q` = 0. With carry-in 1 they give `sum_q` = 0x01 and `cout_q` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset that clears the outputs |
| a_in | input | W (8) | First operand |
| b_in | input | W (8) | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum_q | output | W (8) | Registered sum |
| cout_q | output | 1 | Registered carry out of the top bit |

## Verification
The hardest cases to reach are those where a carry must cross from one chain's bit positions into the other chain's. Neither chain ever reads the other. The crossing happens only through the OR-propagate gating and the sum XOR at the bit above. A wrong index on either side therefore shows up only for operand pairs with a particular generate and propagate layout. The bench reaches all of these layouts with a full sweep of both operands under both carry-in values. It also adds directed vectors that start a carry on one chain and require it to end on the other.

// File: rtl/sca_pkg.sv
package sca_pkg;
  // Default operand width; the split-chain scheme needs an even width.
  localparam int unsigned SCA_WIDTH = 8;
  // Index offset used when chains reach two positions below bit 0.
  localparam int unsigned SCA_REACH = 2;
endpackage

// File: rtl/sca_bit_terms.sv
module sca_bit_terms #(
  parameter int unsigned W = sca_pkg::SCA_WIDTH
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] gen,
  output logic [W-1:0] xprop,
  output logic [W-1:0] oprop
);
  // Per-bit generate, XOR-propagate and OR-propagate.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen[i]   = a[i] & b[i];
    assign xprop[i] = a[i] ^ b[i];
    assign oprop[i] = a[i] | b[i];
  end
endmodule

// File: rtl/sca_group_terms.sv
module sca_group_terms #(
  parameter int unsigned W = sca_pkg::SCA_WIDTH
) (
  input  logic [W-1:0] gen,
  input  logic [W-1:0] xprop,
  input  logic [W-1:0] oprop,
  input  logic         cin,
  output logic [W-1:0] grp_gen,
  output logic [W-1:0] grp_prop
);
  localparam int unsigned R = sca_pkg::SCA_REACH;

  // Shifted views: gen_lo[i] is generate of bit i-1 (carry-in below bit 0),
  // xp_lo[i] is XOR-propagate of bit i-1, op_lo[i] is OR-propagate of bit i-2
  // (taken as 1 below the operand).
  logic [W-1:0] gen_lo;
  logic [W-1:0] xp_lo;
  logic [W-1:0] op_lo;

  assign gen_lo = {gen[W-2:0], cin};
  assign xp_lo  = {xprop[W-2:0], 1'b0};
  assign op_lo  = {oprop[W-1-R:0], {R{1'b1}}};

  for (genvar i = 0; i < W; i++) begin : g_grp
    assign grp_gen[i]  = gen[i] | gen_lo[i];
    assign grp_prop[i] = xprop[i] & xp_lo[i] & op_lo[i];
  end
endmodule

// File: rtl/sca_pseudo_chain.sv
module sca_pseudo_chain #(
  parameter int unsigned W      = sca_pkg::SCA_WIDTH,
  parameter int unsigned PARITY = 0
) (
  input  logic [W-1:0] grp_gen,
  input  logic [W-1:0] grp_prop,
  input  logic         cin,
  output logic [W-1:0] pseudo
);
  localparam int unsigned R = sca_pkg::SCA_REACH;

  // chain[i+R] holds the pseudo-carry of bit i; chain[0] seeds the even
  // chain with 0, chain[1] seeds the odd chain with the carry-in.
  logic [W+R-1:0] chain;

  always_comb begin
    chain    = '0;
    chain[1] = cin;
    for (int i = PARITY; i < W; i += 2) begin
      chain[i+R] = grp_gen[i] | (grp_prop[i] & chain[i]);
    end
    pseudo = chain[W+R-1:R];
  end
endmodule

// File: rtl/sca_recover.sv
module sca_recover #(
  parameter int unsigned W = sca_pkg::SCA_WIDTH
) (
  input  logic [W-1:0] xprop,
  input  logic [W-1:0] oprop,
  input  logic [W-1:0] pseudo,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] carry;

  assign carry = oprop & pseudo;
  assign sum   = xprop ^ {carry[W-2:0], cin};
  assign cout  = carry[W-1];
endmodule

// File: rtl/split_cla_adder.sv
module split_cla_adder #(
  parameter int unsigned W = sca_pkg::SCA_WIDTH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         c_in,
  output logic [W-1:0] sum_q,
  output logic         cout_q
);
  logic [W-1:0] gen, xprop, oprop;
  logic [W-1:0] grp_gen, grp_prop;
  logic [W-1:0] pseudo_part [2];
  logic [W-1:0] pseudo;
  logic [W-1:0] sum_d;
  logic         cout_d;

  sca_bit_terms #(.W(W)) u_terms (
    .a(a_in), .b(b_in), .gen(gen), .xprop(xprop), .oprop(oprop)
  );

  sca_group_terms #(.W(W)) u_group (
    .gen(gen), .xprop(xprop), .oprop(oprop), .cin(c_in),
    .grp_gen(grp_gen), .grp_prop(grp_prop)
  );

  // One chain per bit parity; neither reads the other.
  for (genvar k = 0; k < 2; k++) begin : g_chain
    sca_pseudo_chain #(.W(W), .PARITY(k)) u_chain (
      .grp_gen(grp_gen), .grp_prop(grp_prop), .cin(c_in),
      .pseudo(pseudo_part[k])
    );
  end

  assign pseudo = pseudo_part[0] | pseudo_part[1];

  sca_recover #(.W(W)) u_recover (
    .xprop(xprop), .oprop(oprop), .pseudo(pseudo), .cin(c_in),
    .sum(sum_d), .cout(cout_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      sum_q  <= sum_d;
      cout_q <= cout_d;
    end
  end
endmodule

// File: rtl/sca_adder_chk.sv
module sca_adder_chk #(
  parameter int unsigned W = sca_pkg::SCA_WIDTH
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         c_in,
  input logic [W-1:0] sum_q,
  input logic         cout_q
);
  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ({cout_q, sum_q} ==
      ({1'b0, $past(a_in)} + {1'b0, $past(b_in)} + {{W{1'b0}}, $past(c_in)}))); // R1

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (sum_q == '0 && !cout_q)); // R2

  AST_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(a_in) == '1 && $past(b_in) == '1 && !$past(c_in))
      |-> (cout_q && sum_q == {{(W-1){1'b1}}, 1'b0})); // R3

  AST_FULL_PROPAGATE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(a_in) ^ $past(b_in)) == '1 && $past(c_in))
      |-> (cout_q && sum_q == '0)); // R4

  AST_ZERO_OPS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(a_in) == '0 && $past(b_in) == '0)
      |-> (!cout_q && sum_q == {{(W-1){1'b0}}, $past(c_in)})); // R6
endmodule

bind split_cla_adder sca_adder_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .c_in(c_in),
  .sum_q(sum_q), .cout_q(cout_q)
);

// File: tb/sim_split_cla_adder.sv
module sim_split_cla_adder;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int WATCHDOG   = 190000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '1;
  logic [W-1:0] b_in = '1;
  logic         c_in = 1'b1;
  logic [W-1:0] sum_q;
  logic         cout_q;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  split_cla_adder #(.W(W)) u0 (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .sum_q(sum_q), .cout_q(cout_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: actual=0x%03h expected=0x%03h (a=0x%02h b=0x%02h cin=%0d)",
               req, actual, expected, a_in, b_in, c_in);
    end
  endtask

  // Present operands after a falling edge, capture on the next rising edge,
  // sample one time unit later.
  task automatic apply(input string req, input int a, input int b, input int ci);
    int expv;
    @(negedge clk);
    a_in = a[W-1:0];
    b_in = b[W-1:0];
    c_in = ci[0];
    expv = a + b + ci;
    @(posedge clk);
    #1;
    check(req, int'({cout_q, sum_q}), expv);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R2: reset holds outputs at zero despite all-ones operands
    repeat (2) @(posedge clk);
    #1;
    check("R2", int'({cout_q, sum_q}), 0);
    @(negedge clk);
    rst = 1'b0;

    // Directed corner cases
    apply("R3", 8'hFF, 8'hFF, 0);
    apply("R4", 8'hFF, 8'h00, 1);
    apply("R4", 8'h55, 8'hAA, 1);
    apply("R5", 8'h01, 8'hFF, 0);
    apply("R5", 8'h02, 8'hFE, 0);
    apply("R6", 8'h00, 8'h00, 0);
    apply("R6", 8'h00, 8'h00, 1);

    // R2: reset in mid-run clears a nonzero result
    @(negedge clk);
    rst  = 1'b1;
    a_in = 8'h7F;
    b_in = 8'h81;
    c_in = 1'b1;
    @(posedge clk);
    #1;
    check("R2", int'({cout_q, sum_q}), 0);
    @(negedge clk);
    rst = 1'b0;

    // Full sweep: R3 with carry-in 0, R1 with carry-in 1
    for (int ci = 0; ci < 2; ci++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          apply(ci == 0 ? "R3" : "R1", a, b, ci);
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule